// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Port

This block is a write-only serial slave that holds the divider and mode settings of a frequency synthesizer. A host drives three wires: a serial clock, a data line and an active-low select. While select is low, each rising edge of the serial clock shifts one data bit into an 18-bit frame, most significant bit first. When select returns high, the frame is checked and written to one register. The frame must start with a leading 1. Its final address bits pick one of five targets: two feedback divide values, two reference divide values (each paired with a charge-pump code), or the control word.

The three serial wires are sampled by the block's own system clock. They are assumed to be already synchronized and to hold each level for at least one system clock cycle. All five registers are driven out in parallel to the loop logic. After a hard shutdown, the interface is dead until one full serial clock cycle has been seen with select high. A flag tells the loop logic that a divider was written and that a control-word write is still owed.

Top module: `tw_cfg_top`

## Requirements
- R1: While `hardShutN` is low, every register returns to its default: `divM1`=10519, `divM2`=4269, `divR1`=`divR2`=492, both pump codes 2'b11, `ctrlWord`=13'h0B57, and `ctrlRewriteDue`=0.
- R2: A bit on `sdata` is shifted in on each rising `sclk` seen while `selN` is low, first bit = frame bit 17. If more than 18 bits are shifted, the last 18 form the frame.
- R3: After shutdown, shifting is ignored until one full `sclk` cycle (rise then fall) has occurred with `selN` high; after that the port stays initialised.
- R4: A frame with fewer than 18 shifted bits when `selN` rises changes no register.
- R5: A frame whose bit 17 (start bit) is 0 changes no register.
- R6: Frame bits [1:0]=00 load `divR1`←bits[12:2] and `pumpCode1`←bits[14:13]. Bits [1:0]=01 load `divR2`/`pumpCode2` from the same fields. Bits [16:15] are ignored.
- R7: Frame bits [2:0]=010 load `divM1`←bits[16:3]; 011 loads `divM2` from the same field.
- R8: Frame bits [2:0]=110 load `ctrlWord`←bits[15:3]; code 111 is discarded with no register change.
- R9: `ctrlRewriteDue` sets on any accepted M or R write and clears on an accepted control-word write.
- R10: `ctrlWord` bit 0 (soft shutdown) at 0 has no effect on the port; later frames are still accepted.
- R11: A hard shutdown during a transfer aborts it, restores the defaults, and makes the port uninitialised again (R3).
- R12: The outputs change only on the system clock edge where `selN` is first seen high after a valid frame; a complete frame still being held with `selN` low leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| hardShutN | input | 1 | Active-low hard shutdown, asynchronous clear of all state |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data |
| selN | input | 1 | Active-low frame select; its rising edge commits the frame |
| divM1 | output | 14 | Feedback divide value, set 1 |
| divM2 | output | 14 | Feedback divide value, set 2 |
| divR1 | output | 11 | Reference divide value, set 1 |
| divR2 | output | 11 | Reference divide value, set 2 |
| pumpCode1 | output | 2 | Charge-pump code paired with set 1 |
| pumpCode2 | output | 2 | Charge-pump code paired with set 2 |
| ctrlWord | output | 13 | Control word |
| ctrlRewriteDue | output | 1 | A divider was written since the last control-word write |

## Verification
The bench writes every address code, including the discarded 111.

- Field values with ones in the ignored bits show that bits are placed correctly and that ignored bits stay out.
- Short frames, frames with a zero start bit and frames sent before initialisation tell the three rejection paths apart.
- An over-long frame shows that the last 18 bits count.
- A hard shutdown in the middle of a frame, followed by a write attempted without re-initialisation, separates a full clear from a plain register reset.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  localparam int FRAME_LEN   = 18;
  localparam int PAYLOAD_LEN = FRAME_LEN - 1;
  localparam int CNT_W       = $clog2(FRAME_LEN + 1);
  localparam int M_W         = 14;
  localparam int R_W         = 11;
  localparam int CP_W        = 2;
  localparam int CTRL_W      = 13;
  localparam int NSET        = 2;

  localparam logic [M_W-1:0]    M1_DEF   = 14'd10519;
  localparam logic [M_W-1:0]    M2_DEF   = 14'd4269;
  localparam logic [R_W-1:0]    R_DEF    = 11'd492;
  localparam logic [CP_W-1:0]   CP_DEF   = 2'b11;
  localparam logic [CTRL_W-1:0] CTRL_DEF = 13'h0B57;

  localparam logic [2:0] ADDR_M1   = 3'b010;
  localparam logic [2:0] ADDR_M2   = 3'b011;
  localparam logic [2:0] ADDR_CTRL = 3'b110;

  typedef struct packed {
    logic shift;
    logic commit;
  } twStrobe_t;
endpackage

// File: rtl/tw_cfg_ctrl.sv
module tw_cfg_ctrl
  import tw_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      hardShutN,
  input  logic      sclk,
  input  logic      selN,
  output twStrobe_t strb
);
  logic sclkQ, selQ, primed, armed;
  logic [CNT_W-1:0] bitCnt;
  logic sclkRise, sclkFall, selRise;

  assign sclkRise = sclk & ~sclkQ;
  assign sclkFall = ~sclk & sclkQ;
  assign selRise  = selN & ~selQ;

  always_ff @(posedge clk or negedge hardShutN) begin
    if (!hardShutN) begin
      sclkQ  <= 1'b0;
      selQ   <= 1'b1;
      primed <= 1'b0;
      armed  <= 1'b0;
    end else begin
      sclkQ <= sclk;
      selQ  <= selN;
      if (!selN)         primed <= 1'b0;
      else if (sclkRise) primed <= 1'b1;
      if (selN && sclkFall && primed) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge hardShutN) begin
    if (!hardShutN)                                bitCnt <= '0;
    else if (selN)                                 bitCnt <= '0;
    else if (strb.shift && bitCnt != CNT_W'(FRAME_LEN)) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strb.shift  = armed & ~selN & sclkRise;
    strb.commit = armed & selRise & (bitCnt == CNT_W'(FRAME_LEN));
  end

  // R3: once initialised, the port stays initialised until shutdown
  a_r3_armed_sticky: assert property (@(posedge clk) disable iff (!hardShutN)
    armed |=> armed);
  // R4: the bit counter never exceeds one frame
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!hardShutN)
    bitCnt <= CNT_W'(FRAME_LEN));
  // R2: each accepted shift below saturation advances the counter by one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!hardShutN)
    (strb.shift && bitCnt < CNT_W'(FRAME_LEN)) |=> bitCnt == $past(bitCnt) + 1'b1);
endmodule

// File: rtl/tw_cfg_regs.sv
module tw_cfg_regs
  import tw_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              hardShutN,
  input  logic              sdata,
  input  twStrobe_t         strb,
  output logic [M_W-1:0]    mOut   [NSET],
  output logic [R_W-1:0]    rOut   [NSET],
  output logic [CP_W-1:0]   cpOut  [NSET],
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              rewriteDue
);
  logic [FRAME_LEN-1:0]   frame;
  logic [PAYLOAD_LEN-1:0] payload;
  logic                   accept;
  logic [NSET-1:0]        hitM, hitR;
  logic                   hitCtrl;

  always_ff @(posedge clk or negedge hardShutN) begin
    if (!hardShutN)      frame <= '0;
    else if (strb.shift) frame <= {frame[FRAME_LEN-2:0], sdata};
  end

  assign payload = frame[PAYLOAD_LEN-1:0];
  assign accept  = strb.commit & frame[FRAME_LEN-1];

  always_comb begin
    hitR[0] = accept && payload[1:0] == 2'b00;
    hitR[1] = accept && payload[1:0] == 2'b01;
    hitM[0] = accept && payload[2:0] == ADDR_M1;
    hitM[1] = accept && payload[2:0] == ADDR_M2;
    hitCtrl = accept && payload[2:0] == ADDR_CTRL;
  end

  for (genvar s = 0; s < NSET; s++) begin : g_set
    localparam logic [M_W-1:0] M_INIT = (s == 0) ? M1_DEF : M2_DEF;
    always_ff @(posedge clk or negedge hardShutN) begin
      if (!hardShutN) begin
        mOut[s]  <= M_INIT;
        rOut[s]  <= R_DEF;
        cpOut[s] <= CP_DEF;
      end else begin
        if (hitM[s]) mOut[s] <= payload[PAYLOAD_LEN-1 -: M_W];
        if (hitR[s]) begin
          rOut[s]  <= payload[R_W+1:2];
          cpOut[s] <= payload[R_W+CP_W+1:R_W+2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge hardShutN) begin
    if (!hardShutN) begin
      ctrlOut    <= CTRL_DEF;
      rewriteDue <= 1'b0;
    end else begin
      if (hitCtrl) ctrlOut <= payload[CTRL_W+2:3];
      if (hitCtrl)                  rewriteDue <= 1'b0;
      else if (|hitM || |hitR)      rewriteDue <= 1'b1;
    end
  end

  // R12: no commit strobe, no register change
  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!hardShutN)
    !strb.commit |=> ($stable(ctrlOut) && $stable(mOut[0]) && $stable(mOut[1])
                      && $stable(rOut[0]) && $stable(rOut[1]) && $stable(rewriteDue)));
  // R5: a commit with a zero start bit leaves every register alone
  a_r5_bad_start: assert property (@(posedge clk) disable iff (!hardShutN)
    (strb.commit && !frame[FRAME_LEN-1]) |=> ($stable(ctrlOut) && $stable(mOut[0])
      && $stable(mOut[1]) && $stable(rOut[0]) && $stable(rOut[1])));
  // R9: an accepted control-word frame clears the rewrite flag
  a_r9_due_cleared: assert property (@(posedge clk) disable iff (!hardShutN)
    (strb.commit && frame[FRAME_LEN-1] && frame[2:0] == ADDR_CTRL) |=> !rewriteDue);
  // R8: code 111 never changes the control word
  a_r8_discard_111: assert property (@(posedge clk) disable iff (!hardShutN)
    (strb.commit && frame[2:0] == 3'b111) |=> $stable(ctrlOut));
endmodule

// File: rtl/tw_cfg_top.sv
module tw_cfg_top
  import tw_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              hardShutN,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              selN,
  output logic [M_W-1:0]    divM1,
  output logic [M_W-1:0]    divM2,
  output logic [R_W-1:0]    divR1,
  output logic [R_W-1:0]    divR2,
  output logic [CP_W-1:0]   pumpCode1,
  output logic [CP_W-1:0]   pumpCode2,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              ctrlRewriteDue
);
  twStrobe_t         strb;
  logic [M_W-1:0]    mOut  [NSET];
  logic [R_W-1:0]    rOut  [NSET];
  logic [CP_W-1:0]   cpOut [NSET];

  tw_cfg_ctrl u_ctrl (
    .clk(clk), .hardShutN(hardShutN), .sclk(sclk), .selN(selN), .strb(strb)
  );

  tw_cfg_regs u_regs (
    .clk(clk), .hardShutN(hardShutN), .sdata(sdata), .strb(strb),
    .mOut(mOut), .rOut(rOut), .cpOut(cpOut),
    .ctrlOut(ctrlWord), .rewriteDue(ctrlRewriteDue)
  );

  assign divM1     = mOut[0];
  assign divM2     = mOut[1];
  assign divR1     = rOut[0];
  assign divR2     = rOut[1];
  assign pumpCode1 = cpOut[0];
  assign pumpCode2 = cpOut[1];
endmodule

// File: tb/test_tw_cfg_top.sv
module test_tw_cfg_top;
  logic clk = 1'b0;
  logic hardShutN = 1'b0, sclk = 1'b0, sdata = 1'b0, selN = 1'b1;
  logic [13:0] divM1, divM2;
  logic [10:0] divR1, divR2;
  logic [1:0]  pumpCode1, pumpCode2;
  logic [12:0] ctrlWord;
  logic        ctrlRewriteDue;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  tw_cfg_top i_tw_cfg_top (
    .clk(clk), .hardShutN(hardShutN), .sclk(sclk), .sdata(sdata), .selN(selN),
    .divM1(divM1), .divM2(divM2), .divR1(divR1), .divR2(divR2),
    .pumpCode1(pumpCode1), .pumpCode2(pumpCode2),
    .ctrlWord(ctrlWord), .ctrlRewriteDue(ctrlRewriteDue)
  );

  task automatic tickN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse();
    sclk = 1'b1; tickN(3);
    sclk = 1'b0; tickN(3);
  endtask

  task automatic initBus();
    selN = 1'b1; tickN(2); pulse();
  endtask

  task automatic shiftBits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i]; tickN(1); pulse();
    end
  endtask

  task automatic sendBits(logic [31:0] v, int n);
    selN = 1'b0; tickN(2);
    shiftBits(v, n);
    selN = 1'b1; tickN(3);
  endtask

  function automatic logic [17:0] frM(logic [13:0] m, logic sel2);
    return {1'b1, m, 2'b01, sel2};
  endfunction
  function automatic logic [17:0] frR(logic [1:0] cp, logic [10:0] r, logic sel2);
    return {1'b1, 2'b11, cp, r, 1'b0, sel2};
  endfunction
  function automatic logic [17:0] frC(logic [12:0] c);
    return {1'b1, 1'b1, c, 3'b110};
  endfunction

  task automatic doReset();
    hardShutN = 1'b0; tickN(3); hardShutN = 1'b1; tickN(2);
  endtask

  task automatic t_reset();
    doReset();
    chk("R1", "divM1", divM1, 10519);
    chk("R1", "divM2", divM2, 4269);
    chk("R1", "divR1", divR1, 492);
    chk("R1", "divR2", divR2, 492);
    chk("R1", "pump", {pumpCode1, pumpCode2}, 4'b1111);
    chk("R1", "ctrlWord", ctrlWord, 13'h0B57);
    chk("R1", "due", ctrlRewriteDue, 0);
  endtask

  task automatic t_uninit();
    sendBits(frM(14'd100, 1'b0), 18);
    chk("R3", "divM1 before init", divM1, 10519);
    initBus();
    sendBits(frM(14'd100, 1'b0), 18);
    chk("R3", "divM1 after init", divM1, 100);
    chk("R9", "due after M write", ctrlRewriteDue, 1);
  endtask

  task automatic t_rWrites();
    sendBits(frR(2'b01, 11'd777, 1'b0), 18);
    chk("R6", "divR1", divR1, 777);
    chk("R6", "pumpCode1", pumpCode1, 2'b01);
    chk("R6", "divR2 untouched", divR2, 492);
    sendBits(frR(2'b10, 11'd5, 1'b1), 18);
    chk("R6", "divR2", divR2, 5);
    chk("R6", "pumpCode2", pumpCode2, 2'b10);
    chk("R6", "divM1 untouched", divM1, 100);
  endtask

  task automatic t_mWrite();
    sendBits(frM(14'd16383, 1'b1), 18);
    chk("R7", "divM2", divM2, 16383);
    chk("R7", "divM1 untouched", divM1, 100);
  endtask

  task automatic t_ctrl();
    sendBits(frC(13'h1AAA), 18);
    chk("R8", "ctrlWord", ctrlWord, 13'h1AAA);
    chk("R9", "due cleared", ctrlRewriteDue, 0);
    sendBits({1'b1, 14'h3FFF, 3'b111}, 18);
    chk("R8", "111 ctrlWord", ctrlWord, 13'h1AAA);
    chk("R8", "111 divM1", divM1, 100);
    chk("R8", "111 divM2", divM2, 16383);
    chk("R8", "111 due", ctrlRewriteDue, 0);
  endtask

  task automatic t_reject();
    logic [17:0] f;
    f = frM(14'd9, 1'b0);
    sendBits({15'd0, f[16:0]}, 17);
    chk("R4", "short frame", divM1, 100);
    f[17] = 1'b0;
    sendBits({14'd0, f}, 18);
    chk("R5", "zero start bit", divM1, 100);
    chk("R5", "due unchanged", ctrlRewriteDue, 0);
  endtask

  task automatic t_long();
    sendBits({12'd0, 2'b11, frM(14'd1234, 1'b0)}, 20);
    chk("R2", "last 18 bits used", divM1, 1234);
  endtask

  task automatic t_hold();
    logic [17:0] f;
    f = frM(14'd4321, 1'b0);
    selN = 1'b0; tickN(2);
    shiftBits({14'd0, f}, 18);
    tickN(4);
    chk("R12", "held before select rises", divM1, 1234);
    selN = 1'b1; tickN(3);
    chk("R12", "written after select rises", divM1, 4321);
  endtask

  task automatic t_soft();
    sendBits(frC(13'h0B56), 18);
    chk("R10", "soft shutdown bit", ctrlWord, 13'h0B56);
    sendBits(frM(14'd77, 1'b1), 18);
    chk("R10", "write accepted in soft shutdown", divM2, 77);
    chk("R9", "due set by M2", ctrlRewriteDue, 1);
  endtask

  task automatic t_hard();
    logic [17:0] f;
    f = frM(14'd55, 1'b0);
    selN = 1'b0; tickN(2);
    shiftBits({14'd0, f}, 9);
    hardShutN = 1'b0; tickN(2);
    chk("R11", "divM2 during shutdown", divM2, 4269);
    chk("R11", "ctrlWord during shutdown", ctrlWord, 13'h0B57);
    shiftBits({14'd0, f}, 9);
    hardShutN = 1'b1; tickN(2);
    selN = 1'b1; tickN(3);
    chk("R11", "aborted frame", divM1, 10519);
    sendBits(f, 18);
    chk("R11", "uninit after shutdown", divM1, 10519);
    initBus();
    sendBits(f, 18);
    chk("R11", "write after re-init", divM1, 55);
  endtask

  initial begin
    tickN(1);
    t_reset();
    t_uninit();
    t_rWrites();
    t_mWrite();
    t_ctrl();
    t_reject();
    t_long();
    t_hold();
    t_soft();
    t_hard();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule